// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is a memory-mapped real-time clock for a simple single-cycle register bus. An external one-second tick advances a 32-bit seconds up-counter and, alongside it, a down-counter. Software loads the down-counter with the bitwise complement of the up-counter, so the two always add up to all ones. Two 32-bit match registers are each compared against the up-counter. A match sets a sticky status bit. The status bits, gated by enables in the control register, drive an interrupt output and a wake output. The wake output can also be forced high.

Software holds the counters with a disable bit while it loads them. A software-reset bit clears the counters and the status. A 32-bit key word and a 32-word scratch RAM are not cleared by any reset. Boot code writes a known constant into the key word and checks for it on a later start, to tell a warm start from a cold one.

Register word offsets:
- 0x00: up-counter
- 0x04: down-counter
- 0x08: match 0
- 0x0C: match 1
- 0x10: control
- 0x14: status
- 0x18: key
- 0x80 to 0xFC: scratch RAM

Top module: `sec_rtc`

## Requirements
- R1: After rst_ni, control, status and both counters read 0 and both match registers read 0xFFFFFFFF. Any offset below 0x80 other than 0x00 to 0x18 reads 0.
- R2: On a tick_i cycle with counting enabled, the up-counter increments by one and the down-counter decrements by one, both wrapping modulo 2^32.
- R3: A bus write to a counter loads it. When the write and a tick fall on the same cycle, the written value wins.
- R4: While control bit 6 is 1, ticks leave both counters unchanged.
- R5: Status bit 0 (match 0) and status bit 1 (match 1) are set by the tick that makes the up-counter equal to that match register. A match register holding 0xFFFFFFFF never sets its bit.
- R6: Status bit 2 is set when a match sets its status bit while the wake-route bit for that match is 1. The wake-route bits are control bit 2 for match 0 and control bit 3 for match 1.
- R7: Status bits are sticky and are cleared by writing 1 to them. A match that occurs in the same cycle as a clear of its bit leaves the bit set.
- R8: irq_o is 1 exactly when status bit 0 is 1 with control bit 0 set, or status bit 1 is 1 with control bit 1 set.
- R9: wake_o is 1 exactly when any of these holds:
  - control bit 7 is 1;
  - status bit 0 and control bit 2 are both 1;
  - status bit 1 and control bit 3 are both 1.
- R10: While control bit 4 is 1, both counters and all status bits are held at 0. The match registers, key and scratch RAM are left unchanged.
- R11: The key word at 0x18 reads back what was written and keeps its value across rst_ni.
- R12: The scratch RAM holds 32 words at 0x80 + 4*i and keeps its contents across rst_ni.
- R13: Control bit 5 is not implemented and reads 0; the other seven control bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle seconds tick, synchronous to clk_i |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| irq_o | output | 1 | Match interrupt |
| wake_o | output | 1 | Wake output |

## Verification
The assertions assume that tick_i is a single-cycle pulse synchronous to clk_i, and that a write decodes from addr_i in the cycle req_i and we_i are high. The stimulus changes every input only at the falling clock edge and holds it for one full cycle, so the properties never see a mid-cycle change. It also drives ticks and bus writes in the same cycle on purpose, to exercise the priority of a counter write and of a status set over the tick and the clear. The sticky-status and hold properties exclude the cycles in which software itself writes the bit or counter they watch.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW = 32;

  // word offsets within the register window
  localparam logic [4:0] W_UP   = 5'd0;
  localparam logic [4:0] W_DN   = 5'd1;
  localparam logic [4:0] W_M0   = 5'd2;
  localparam logic [4:0] W_M1   = 5'd3;
  localparam logic [4:0] W_CTRL = 5'd4;
  localparam logic [4:0] W_STAT = 5'd5;
  localparam logic [4:0] W_KEY  = 5'd6;

  // control bit positions
  localparam int unsigned CB_IE0   = 0;
  localparam int unsigned CB_IE1   = 1;
  localparam int unsigned CB_WK0   = 2;
  localparam int unsigned CB_WK1   = 3;
  localparam int unsigned CB_SRST  = 4;
  localparam int unsigned CB_HOLD  = 6;
  localparam int unsigned CB_FORCE = 7;
  localparam logic [7:0]  CTRL_MASK = 8'hDF;

  localparam int unsigned N_MATCH = 2;
  localparam int unsigned SB_WAKE = 2;
endpackage

// File: rtl/rtc_counters.sv
module rtc_counters #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic          ld_up_i,
  input  logic          ld_dn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] dn_o,
  output logic          step_up_o,
  output logic [DW-1:0] up_nxt_o
);
  logic [DW-1:0] up_q, dn_q;
  logic          run;

  assign run       = tick_i & ~hold_i & ~clr_i;
  assign step_up_o = run & ~ld_up_i;
  assign up_nxt_o  = up_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (clr_i) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      if (ld_up_i)   up_q <= wdata_i;
      else if (run)  up_q <= up_nxt_o;
      if (ld_dn_i)   dn_q <= wdata_i;
      else if (run)  dn_q <= dn_q - 1'b1;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/rtc_match_unit.sv
module rtc_match_unit #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  input  logic [DW-1:0] up_nxt_i,
  output logic [DW-1:0] match_o,
  output logic          hit_o
);
  logic [DW-1:0] match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   match_q <= '1;
    else if (wr_i) match_q <= wdata_i;
  end

  // all-ones is the disarmed value
  assign hit_o   = step_i && (up_nxt_i == match_q) && (match_q != '1);
  assign match_o = match_q;
endmodule

// File: rtl/rtc_scratch.sv
module rtc_scratch #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WORDS = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
  parameter int unsigned AW        = 8,
  parameter int unsigned RAM_WORDS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [rtc_pkg::DW-1:0] wdata_i,
  output logic [rtc_pkg::DW-1:0] rdata_o,
  output logic                  irq_o,
  output logic                  wake_o
);
  import rtc_pkg::*;

  localparam int unsigned RIW = $clog2(RAM_WORDS);
  localparam int unsigned NM  = N_MATCH;

  logic          wr, sel_ram;
  logic [4:0]    widx;
  logic [RIW-1:0] ridx;
  logic          wr_up, wr_dn, wr_ctrl, wr_stat, wr_key, wr_ram;
  logic [NM-1:0] wr_m, hit;
  logic [DW-1:0] match_v [NM];
  logic [DW-1:0] cnt_up, cnt_dn, up_nxt, ram_rd;
  logic          step_up;
  logic [7:0]    ctrl_q;
  logic [2:0]    stat_q, stat_set, stat_clr;
  logic [DW-1:0] key_q;
  logic          srst;

  assign wr      = req_i & we_i;
  assign sel_ram = addr_i[AW-1];
  assign widx    = addr_i[6:2];
  assign ridx    = addr_i[RIW+1:2];

  assign wr_up   = wr & ~sel_ram & (widx == W_UP);
  assign wr_dn   = wr & ~sel_ram & (widx == W_DN);
  assign wr_ctrl = wr & ~sel_ram & (widx == W_CTRL);
  assign wr_stat = wr & ~sel_ram & (widx == W_STAT);
  assign wr_key  = wr & ~sel_ram & (widx == W_KEY);
  assign wr_ram  = wr & sel_ram;
  assign wr_m[0] = wr & ~sel_ram & (widx == W_M0);
  assign wr_m[1] = wr & ~sel_ram & (widx == W_M1);

  assign srst = ctrl_q[CB_SRST];

  rtc_counters #(.DW(DW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (srst),
    .hold_i    (ctrl_q[CB_HOLD]),
    .tick_i    (tick_i),
    .ld_up_i   (wr_up),
    .ld_dn_i   (wr_dn),
    .wdata_i   (wdata_i),
    .up_o      (cnt_up),
    .dn_o      (cnt_dn),
    .step_up_o (step_up),
    .up_nxt_o  (up_nxt)
  );

  for (genvar g = 0; g < NM; g++) begin : g_match
    rtc_match_unit #(.DW(DW)) u_m (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_m[g]),
      .wdata_i  (wdata_i),
      .step_i   (step_up),
      .up_nxt_i (up_nxt),
      .match_o  (match_v[g]),
      .hit_o    (hit[g])
    );
  end

  rtc_scratch #(.DW(DW), .WORDS(RAM_WORDS)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_ram),
    .idx_i   (ridx),
    .wdata_i (wdata_i),
    .rdata_o (ram_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata_i[7:0] & CTRL_MASK;
  end

  assign stat_set = {(hit[0] & ctrl_q[CB_WK0]) | (hit[1] & ctrl_q[CB_WK1]), hit};
  assign stat_clr = wr_stat ? wdata_i[2:0] : 3'b000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stat_q <= '0;
    else if (srst) stat_q <= '0;
    else           stat_q <= (stat_q & ~stat_clr) | stat_set;
  end

  // retained across every reset
  always_ff @(posedge clk_i) begin
    if (wr_key) key_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ram) rdata_o = ram_rd;
    else begin
      unique case (widx)
        W_UP:    rdata_o = cnt_up;
        W_DN:    rdata_o = cnt_dn;
        W_M0:    rdata_o = match_v[0];
        W_M1:    rdata_o = match_v[1];
        W_CTRL:  rdata_o = {{(DW-8){1'b0}}, ctrl_q};
        W_STAT:  rdata_o = {{(DW-3){1'b0}}, stat_q};
        W_KEY:   rdata_o = key_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o  = (stat_q[0] & ctrl_q[CB_IE0]) | (stat_q[1] & ctrl_q[CB_IE1]);
  assign wake_o = ctrl_q[CB_FORCE] | (stat_q[0] & ctrl_q[CB_WK0]) | (stat_q[1] & ctrl_q[CB_WK1]);
endmodule

module sec_rtc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_up,
  input logic        wr_stat,
  input logic [31:0] wdata_i,
  input logic [7:0]  ctrl_q,
  input logic [2:0]  stat_q,
  input logic [31:0] cnt_up,
  input logic [31:0] m0,
  input logic        irq_o,
  input logic        wake_o
);
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl_q[6] && !ctrl_q[4] && !wr_up) |=> (cnt_up == $past(cnt_up) + 32'd1));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[6] && !ctrl_q[4] && !wr_up) |=> $stable(cnt_up));

  a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[4] |=> (cnt_up == 32'd0 && stat_q == 3'd0));

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !ctrl_q[4] && !(wr_stat && wdata_i[0])) |=> stat_q[0]);

  a_r5_no_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> ($past(m0) != 32'hFFFF_FFFF));

  a_r8_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && ctrl_q[0]) |-> irq_o);

  a_r9_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[7] |-> wake_o);
endmodule

bind sec_rtc sec_rtc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_up   (wr_up),
  .wr_stat (wr_stat),
  .wdata_i (wdata_i),
  .ctrl_q  (ctrl_q),
  .stat_q  (stat_q),
  .cnt_up  (cnt_up),
  .m0      (match_v[0]),
  .irq_o   (irq_o),
  .wake_o  (wake_o)
);

// File: tb/sim_sec_rtc.sv
`timescale 1ns/1ps
module sim_sec_rtc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;

  int n_chk = 0, n_fail = 0;
  logic [31:0] last_rd;

  always #2.5 clk = ~clk;

  sec_rtc u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // reference model
  logic [31:0] m_up, m_dn, m_m0, m_m1, m_key;
  logic [31:0] m_ram [32];
  logic [7:0]  m_ctrl;
  logic [2:0]  m_st;
  logic        b_wr, b_ram, b_wup, b_wdn, b_adv, b_advd, b_h0, b_h1, b_hw;
  logic [4:0]  b_idx;
  logic [2:0]  b_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_up = 0; m_dn = 0; m_m0 = '1; m_m1 = '1; m_ctrl = 0; m_st = 0;
    end else begin
      b_wr  = req && we;
      b_ram = addr[7];
      b_idx = addr[6:2];
      b_wup = b_wr && !b_ram && b_idx == 0;
      b_wdn = b_wr && !b_ram && b_idx == 1;
      b_adv  = tick && !m_ctrl[6] && !m_ctrl[4] && !b_wup;
      b_advd = tick && !m_ctrl[6] && !m_ctrl[4] && !b_wdn;
      b_h0 = b_adv && (m_up + 32'd1 == m_m0) && m_m0 != '1;
      b_h1 = b_adv && (m_up + 32'd1 == m_m1) && m_m1 != '1;
      b_hw = (b_h0 && m_ctrl[2]) || (b_h1 && m_ctrl[3]);
      b_clr = (b_wr && !b_ram && b_idx == 5) ? wdata[2:0] : 3'b0;
      if (m_ctrl[4]) begin
        m_st = 0; m_up = 0; m_dn = 0;
      end else begin
        m_st = (m_st & ~b_clr) | {b_hw, b_h1, b_h0};
        if (b_wup) m_up = wdata; else if (b_adv) m_up = m_up + 1;
        if (b_wdn) m_dn = wdata; else if (b_advd) m_dn = m_dn - 1;
      end
      if (b_wr && b_ram) m_ram[addr[6:2]] = wdata;
      if (b_wr && !b_ram) begin
        if (b_idx == 2) m_m0 = wdata;
        if (b_idx == 3) m_m1 = wdata;
        if (b_idx == 4) m_ctrl = wdata[7:0] & 8'hDF;
        if (b_idx == 6) m_key = wdata;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a[7]) return m_ram[a[6:2]];
    case (a[6:2])
      5'd0: return m_up;
      5'd1: return m_dn;
      5'd2: return m_m0;
      5'd3: return m_m1;
      5'd4: return {24'd0, m_ctrl};
      5'd5: return {29'd0, m_st};
      5'd6: return m_key;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle; compares outputs with the model every clock
  task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic t);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; tick = t;
    #1;
    chk("R8 irq_o vs model", {31'd0, irq}, {31'd0, |(m_st[1:0] & m_ctrl[1:0])});
    chk("R9 wake_o vs model", {31'd0, wake},
        {31'd0, m_ctrl[7] | (m_st[0] & m_ctrl[2]) | (m_st[1] & m_ctrl[3])});
    if (r && !w) begin
      last_rd = rdata;
      chk("R1 rdata vs model", rdata, m_read(a));
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, 0);
  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 1);
  endtask
  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    cyc(1, 0, a, 0, 0);
    chk(tag, last_rd, exp);
  endtask
  task automatic idle();
    cyc(0, 0, 8'h00, 0, 0);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_chk("R1 ctrl reset", 8'h10, 32'h0);
    rd_chk("R1 stat reset", 8'h14, 32'h0);
    rd_chk("R1 up reset", 8'h00, 32'h0);
    rd_chk("R1 m0 reset", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R1 m1 reset", 8'h0C, 32'hFFFF_FFFF);
    rd_chk("R1 unmapped", 8'h40, 32'h0);
    // R11 key, R12 RAM
    wr(8'h18, 32'hB5C1_3F27);
    rd_chk("R11 key readback", 8'h18, 32'hB5C1_3F27);
    wr(8'h80, 32'h1111_0000);
    wr(8'h94, 32'h5555_AAAA);
    wr(8'hFC, 32'hDEAD_BEEF);
    rd_chk("R12 ram word0", 8'h80, 32'h1111_0000);
    rd_chk("R12 ram word5", 8'h94, 32'h5555_AAAA);
    rd_chk("R12 ram word31", 8'hFC, 32'hDEAD_BEEF);
    // R4 hold while loading
    wr(8'h10, 32'h40);
    wr(8'h00, 32'd100);
    wr(8'h04, 32'hFFFF_FF9B);
    tk(4);
    rd_chk("R4 up held", 8'h00, 32'd100);
    rd_chk("R4 dn held", 8'h04, 32'hFFFF_FF9B);
    // R2 counting
    wr(8'h10, 32'h0);
    tk(3);
    rd_chk("R2 up count", 8'h00, 32'd103);
    rd_chk("R2 dn count", 8'h04, 32'hFFFF_FF98);
    // R3 write beats tick
    cyc(1, 1, 8'h00, 32'd500, 1);
    rd_chk("R3 write wins", 8'h00, 32'd500);
    // R5/R6/R8/R9 match 0 with irq and wake route
    wr(8'h08, 32'd503);
    wr(8'h10, 32'h05);
    tk(2);
    rd_chk("R5 before match", 8'h14, 32'h0);
    chk("R8 irq low before match", {31'd0, irq}, 32'd0);
    tk(1);
    rd_chk("R5 R6 match0 status", 8'h14, 32'h5);
    chk("R8 irq on match", {31'd0, irq}, 32'd1);
    chk("R9 wake on routed match", {31'd0, wake}, 32'd1);
    tk(2);
    rd_chk("R7 sticky", 8'h14, 32'h5);
    wr(8'h14, 32'h1);
    rd_chk("R7 w1c bit0", 8'h14, 32'h4);
    chk("R8 irq after clear", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'h4);
    rd_chk("R7 w1c bit2", 8'h14, 32'h0);
    // R5 disarmed value and wrap
    wr(8'h10, 32'h0);
    wr(8'h00, 32'hFFFF_FFFE);
    tk(1);
    rd_chk("R5 all-ones no alarm", 8'h14, 32'h0);
    rd_chk("R2 up reaches max", 8'h00, 32'hFFFF_FFFF);
    tk(1);
    rd_chk("R2 up wraps", 8'h00, 32'h0);
    // R7 set beats clear
    wr(8'h00, 32'd10);
    wr(8'h0C, 32'd11);
    wr(8'h10, 32'h02);
    cyc(1, 1, 8'h14, 32'h2, 1);
    rd_chk("R7 set beats clear", 8'h14, 32'h2);
    chk("R8 irq match1", {31'd0, irq}, 32'd1);
    // R9 force
    wr(8'h10, 32'h80);
    idle();
    chk("R9 force high", {31'd0, wake}, 32'd1);
    chk("R8 irq disabled", {31'd0, irq}, 32'd0);
    // R13 control mask
    wr(8'h10, 32'hFF);
    rd_chk("R13 ctrl bit5", 8'h10, 32'hDF);
    // R10 soft reset
    wr(8'h10, 32'h10);
    tk(2);
    rd_chk("R10 up cleared", 8'h00, 32'h0);
    rd_chk("R10 dn cleared", 8'h04, 32'h0);
    rd_chk("R10 stat cleared", 8'h14, 32'h0);
    rd_chk("R10 m0 kept", 8'h08, 32'd503);
    rd_chk("R10 key kept", 8'h18, 32'hB5C1_3F27);
    rd_chk("R10 ram kept", 8'h94, 32'h5555_AAAA);
    wr(8'h10, 32'h0);
    tk(1);
    rd_chk("R2 counts after soft reset", 8'h00, 32'd1);
    // R11/R12 retained over rst_ni
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R11 key retained", 8'h18, 32'hB5C1_3F27);
    rd_chk("R12 ram retained", 8'hFC, 32'hDEAD_BEEF);
    rd_chk("R1 ctrl after reset", 8'h10, 32'h0);
    rd_chk("R1 m0 after reset", 8'h08, 32'hFFFF_FFFF);
    rd_chk("R1 up after reset", 8'h00, 32'h0);
    idle();
    finish_run();
  end
endmodule